// File: doc/BRIEF.md
# Two-Output Level Interrupt Controller

This block gathers up to 64 active-high, level-sensitive interrupt lines and presents them to a processor as two request wires: a normal request (`irqOut`) and a fast request (`fiqOut`). Each line has its own unmask bit and its own routing bit. A line that is asserted, unmasked and routed to one output drives that output. Software reaches the block through a simple 32-bit word-addressed register bus. Through it, software programs masks and routing, reads the raw line levels and the masked status of each output, and reads the index of the lowest-numbered active source for each output.

Lines 0 to 31 live in a lower register bank. Lines 32 to 63 live in an upper bank, which exists only when the block is built with `NUM_SRC = 64`. In that bank, line n appears at bit n−32. A line cannot be cleared through the bus. It stays pending for as long as its input is high. The pending register samples the inputs once per clock. Programming writes take effect on the clock edge that accepts them.

Top module: `intc_top`

## Requirements
- R1: After reset, the enable (0x04, 0x24), select (0x08, 0x28), priority (0x14) and error-priority (0x34) registers read 0, and both `irqOut` and `fiqOut` are low.
- R2: The pending register at 0x00 shows the levels of lines 0..31, one clock after they are sampled. The pending register at 0x20 shows lines 32..63 at bits 0..31. A pending bit stays 1 for as long as its input is high.
- R3: Writes to the read-only offsets are ignored. These are pending (0x00, 0x20), status (0x0C, 0x10, 0x2C, 0x30) and index (0x18, 0x1C).
- R4: The enable registers (0x04 lower, 0x24 upper) read back what was written. A 1 unmasks the line from the next clock. A 0 blocks it from both outputs.
- R5: The select registers (0x08, 0x28) route a line to the normal request when the bit is 0 and to the fast request when it is 1.
- R6: The normal status registers (0x0C, 0x2C) read pending AND enable AND NOT select. The fast status registers (0x10, 0x30) read pending AND enable AND select.
- R7: `irqOut` is the OR of all normal status bits, and `fiqOut` is the OR of all fast status bits.
- R8: The index registers (0x18 normal, 0x1C fast) scan the combined 64-bit status. They return the lowest-numbered set line in bits [5:0] with bits [31:6] zero, or 0x80000000 when no line is set.
- R9: The priority register (0x14) and the error-priority enable register (0x34) are plain 32-bit storage and read back as written.
- R10: In a 32-line build, the upper-bank offsets 0x20..0x34 read 0 and writes to them have no effect.
- R11: Addresses outside 0x00..0x37 read 0. Writes to them do not alias onto any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Level interrupt lines, active high |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | ADDR_W | Byte address; bits [1:0] ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
Two functions can land in the same clock edge: a line changing level, and a bus write that re-programs that line's unmask bit. The bench provokes this by raising one line and writing the enable register that unmasks it in the same cycle, while the previously active upper line drops. It then judges one clock later that the normal status, the lowest-index register and both request outputs all reflect the new level and the new mask together. A separate 32-line instance shares the bus, which shows that upper-bank writes go nowhere there.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // read selector; numeric value equals the word offset (addr[5:2])
  typedef enum logic [3:0] {
    RD_PEND_LO = 4'd0,
    RD_ENA_LO  = 4'd1,
    RD_SEL_LO  = 4'd2,
    RD_IRQ_LO  = 4'd3,
    RD_FIQ_LO  = 4'd4,
    RD_PRI     = 4'd5,
    RD_IRQ_IDX = 4'd6,
    RD_FIQ_IDX = 4'd7,
    RD_PEND_HI = 4'd8,
    RD_ENA_HI  = 4'd9,
    RD_SEL_HI  = 4'd10,
    RD_IRQ_HI  = 4'd11,
    RD_FIQ_HI  = 4'd12,
    RD_ERR     = 4'd13,
    RD_ZERO    = 4'd14
  } rdSel_e;

  typedef struct packed {
    logic   wrEnaLo;
    logic   wrEnaHi;
    logic   wrSelLo;
    logic   wrSelHi;
    logic   wrPri;
    logic   wrErr;
    rdSel_e rdSel;
  } ctrlStrb_t;

  localparam logic [31:0] IDX_NONE = 32'h8000_0000;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrb_t         strb
);

  localparam bit HAS_UPPER = (NUM_SRC > 32);

  logic [3:0] wordIdx;
  logic       inWindow;
  rdSel_e     sel;

  assign wordIdx  = busAddr[5:2];
  assign inWindow = (busAddr[ADDR_W-1:6] == '0);

  always_comb begin
    sel = RD_ZERO;
    if (inWindow) begin
      if (wordIdx <= 4'd7)
        sel = rdSel_e'(wordIdx);
      else if (HAS_UPPER && wordIdx <= 4'd13)
        sel = rdSel_e'(wordIdx);
    end
  end

  always_comb begin
    strb         = '0;
    strb.rdSel   = sel;
    strb.wrEnaLo = busWe && (sel == RD_ENA_LO);
    strb.wrEnaHi = busWe && (sel == RD_ENA_HI);
    strb.wrSelLo = busWe && (sel == RD_SEL_LO);
    strb.wrSelHi = busWe && (sel == RD_SEL_HI);
    strb.wrPri   = busWe && (sel == RD_PRI);
    strb.wrErr   = busWe && (sel == RD_ERR);
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrEnaLo, strb.wrEnaHi, strb.wrSelLo, strb.wrSelHi, strb.wrPri, strb.wrErr})); // R4

  AST_NARROW_NO_HI: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> (HAS_UPPER || !(strb.wrEnaHi || strb.wrSelHi || strb.wrErr))); // R10

  AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (wordIdx == 4'd0 || wordIdx == 4'd3 || wordIdx == 4'd6)) |->
      !(strb.wrEnaLo || strb.wrSelLo || strb.wrPri)); // R3

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [31:0]        busWdata,
  input  ctrlStrb_t          strb,
  output logic [31:0]        busRdata,
  output logic               irqOut,
  output logic               fiqOut
);

  localparam bit HAS_UPPER = (NUM_SRC > 32);

  logic [NUM_SRC-1:0] pendQ;
  logic [31:0]        enaLoQ, selLoQ, priQ, errQ;
  logic [31:0]        enaHi, selHi;
  logic [63:0]        pendW, enaW, selW, irqStat, fiqStat;
  logic [31:0]        irqIdx, fiqIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      enaLoQ <= '0;
      selLoQ <= '0;
      priQ   <= '0;
      errQ   <= '0;
    end else begin
      pendQ <= srcIn;
      if (strb.wrEnaLo) enaLoQ <= busWdata;
      if (strb.wrSelLo) selLoQ <= busWdata;
      if (strb.wrPri)   priQ   <= busWdata;
      if (strb.wrErr)   errQ   <= busWdata;
    end
  end

  generate
    if (HAS_UPPER) begin : gUpper
      logic [31:0] enaHiQ, selHiQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          enaHiQ <= '0;
          selHiQ <= '0;
        end else begin
          if (strb.wrEnaHi) enaHiQ <= busWdata;
          if (strb.wrSelHi) selHiQ <= busWdata;
        end
      end
      assign enaHi = enaHiQ;
      assign selHi = selHiQ;
    end else begin : gNarrow
      assign enaHi = '0;
      assign selHi = '0;
    end
  endgenerate

  assign pendW   = 64'(pendQ);
  assign enaW    = {enaHi, enaLoQ};
  assign selW    = {selHi, selLoQ};
  assign irqStat = pendW & enaW & ~selW;
  assign fiqStat = pendW & enaW & selW;

  function automatic logic [31:0] lowestSet(input logic [63:0] vec);
    logic [31:0] res;
    res = IDX_NONE;
    for (int i = 63; i >= 0; i--) begin
      if (vec[i]) res = {26'd0, 6'(i)};
    end
    return res;
  endfunction

  assign irqIdx = lowestSet(irqStat);
  assign fiqIdx = lowestSet(fiqStat);
  assign irqOut = |irqStat;
  assign fiqOut = |fiqStat;

  always_comb begin
    case (strb.rdSel)
      RD_PEND_LO: busRdata = pendW[31:0];
      RD_ENA_LO:  busRdata = enaLoQ;
      RD_SEL_LO:  busRdata = selLoQ;
      RD_IRQ_LO:  busRdata = irqStat[31:0];
      RD_FIQ_LO:  busRdata = fiqStat[31:0];
      RD_PRI:     busRdata = priQ;
      RD_IRQ_IDX: busRdata = irqIdx;
      RD_FIQ_IDX: busRdata = fiqIdx;
      RD_PEND_HI: busRdata = pendW[63:32];
      RD_ENA_HI:  busRdata = enaHi;
      RD_SEL_HI:  busRdata = selHi;
      RD_IRQ_HI:  busRdata = irqStat[63:32];
      RD_FIQ_HI:  busRdata = fiqStat[63:32];
      RD_ERR:     busRdata = errQ;
      default:    busRdata = '0;
    endcase
  end

  AST_PEND_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> pendW == 64'($past(srcIn))); // R2

  AST_ENA_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnaLo |=> enaLoQ == $past(busWdata)); // R4

  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSelLo |=> selLoQ == $past(busWdata)); // R5

  AST_IDX_POINTS: assert property (@(posedge clk) disable iff (!rstN)
    !irqIdx[31] |-> (irqStat[irqIdx[5:0]] && irqIdx[30:6] == '0)); // R8

  AST_OUT_EXCL_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && fiqOut) |-> ($countones(pendW & enaW) >= 2)); // R7

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               irqOut,
  output logic               fiqOut
);

  ctrlStrb_t strb;

  intc_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busAddr (busAddr),
    .strb    (strb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .busWdata (busWdata),
    .strb     (strb),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );

endmodule

// File: tb/intc_top_test.sv
module intc_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcIn = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, nRdata;
  logic        irqOut, fiqOut, nIrq, nFiq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  intc_top #(.NUM_SRC(64), .ADDR_W(8)) uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  intc_top #(.NUM_SRC(32), .ADDR_W(8)) uutNarrow (
    .clk(clk), .rstN(rstN), .srcIn(srcIn[31:0]), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(nRdata), .irqOut(nIrq), .fiqOut(nFiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic rdN(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = nRdata;
  endtask

  task automatic setSrc(input logic [63:0] v);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(8'h04, v); chk("R1 ena lo", v, 0);
    rd(8'h08, v); chk("R1 sel lo", v, 0);
    rd(8'h14, v); chk("R1 pri", v, 0);
    rd(8'h24, v); chk("R1 ena hi", v, 0);
    rd(8'h28, v); chk("R1 sel hi", v, 0);
    rd(8'h34, v); chk("R1 err", v, 0);
    chk("R1 irqOut", {31'd0, irqOut}, 0);
    chk("R1 fiqOut", {31'd0, fiqOut}, 0);
    rd(8'h18, v); chk("R8 idx none", v, 32'h8000_0000);
  endtask

  task automatic testPending();
    logic [31:0] v;
    setSrc(64'h8000_0001_0000_0005);
    rd(8'h00, v); chk("R2 pend lo", v, 32'h5);
    rd(8'h20, v); chk("R2 pend hi", v, 32'h8000_0001);
    chk("R4 masked irqOut", {31'd0, irqOut}, 0);
  endtask

  task automatic testReadOnly();
    logic [31:0] v;
    busWr(8'h00, 32'h0);
    rd(8'h00, v); chk("R3 pend unwritable", v, 32'h5);
    busWr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R3 status unwritable", v, 32'h0);
    busWr(8'h18, 32'h0);
    rd(8'h18, v); chk("R3 idx unwritable", v, 32'h8000_0000);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    busWr(8'h04, 32'h4);
    rd(8'h04, v); chk("R4 ena readback", v, 32'h4);
    rd(8'h0C, v); chk("R6 irq status", v, 32'h4);
    chk("R7 irqOut", {31'd0, irqOut}, 1);
    rd(8'h18, v); chk("R8 irq idx", v, 32'd2);
  endtask

  task automatic testSelect();
    logic [31:0] v;
    busWr(8'h08, 32'h4);
    rd(8'h0C, v); chk("R5 irq status after route", v, 0);
    rd(8'h10, v); chk("R5 fiq status", v, 32'h4);
    chk("R7 irqOut low", {31'd0, irqOut}, 0);
    chk("R7 fiqOut high", {31'd0, fiqOut}, 1);
    rd(8'h1C, v); chk("R8 fiq idx", v, 32'd2);
    rd(8'h18, v); chk("R8 irq idx none", v, 32'h8000_0000);
  endtask

  task automatic testUpper();
    logic [31:0] v;
    busWr(8'h24, 32'h8000_0000);
    rd(8'h2C, v); chk("R6 irq hi status", v, 32'h8000_0000);
    rd(8'h18, v); chk("R8 idx line 63", v, 32'd63);
    busWr(8'h04, 32'h5);
    rd(8'h18, v); chk("R8 lowest wins", v, 32'd0);
    busWr(8'h28, 32'h8000_0000);
    rd(8'h30, v); chk("R6 fiq hi status", v, 32'h8000_0000);
    rd(8'h2C, v); chk("R5 irq hi cleared", v, 0);
  endtask

  task automatic testCoincident();
    logic [31:0] v;
    @(negedge clk);
    srcIn = 64'h20; busWe = 1'b1; busAddr = 8'h04; busWdata = 32'h20;
    @(negedge clk);
    busWe = 1'b0;
    rd(8'h0C, v); chk("R6 same-cycle status", v, 32'h20);
    rd(8'h18, v); chk("R8 same-cycle idx", v, 32'd5);
    chk("R7 same-cycle irqOut", {31'd0, irqOut}, 1);
    chk("R7 same-cycle fiqOut", {31'd0, fiqOut}, 0);
    setSrc(64'h0);
    chk("R2 level drop irqOut", {31'd0, irqOut}, 0);
    rd(8'h00, v); chk("R2 pend cleared", v, 0);
  endtask

  task automatic testStorage();
    logic [31:0] v;
    busWr(8'h14, 32'hA5A5_1234);
    rd(8'h14, v); chk("R9 pri", v, 32'hA5A5_1234);
    busWr(8'h34, 32'h0000_00FF);
    rd(8'h34, v); chk("R9 err", v, 32'h0000_00FF);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    rd(8'h38, v); chk("R11 read 0x38", v, 0);
    rd(8'h40, v); chk("R11 read 0x40", v, 0);
    busWr(8'h44, 32'h0);
    rd(8'h04, v); chk("R11 no alias", v, 32'h20);
  endtask

  task automatic testNarrow();
    logic [31:0] v;
    busWr(8'h24, 32'hFFFF_FFFF);
    rdN(8'h24, v); chk("R10 narrow ena hi", v, 0);
    rdN(8'h34, v); chk("R10 narrow err", v, 0);
    busWr(8'h04, 32'h1);
    setSrc(64'hFFFF_FFFF_0000_0001);
    rdN(8'h20, v); chk("R10 narrow pend hi", v, 0);
    rdN(8'h0C, v); chk("R10 narrow irq lo", v, 32'h1);
    chk("R10 narrow irqOut", {31'd0, nIrq}, 1);
    rdN(8'h18, v); chk("R10 narrow idx", v, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPending();
    testReadOnly();
    testEnable();
    testSelect();
    testUpper();
    testCoincident();
    testStorage();
    testUnmapped();
    testNarrow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule